// File: doc/BRIEF.md
# Board Identification Shift Register

This block sits in the programmable logic of a dual-slot add-on card and lets a host read the card's 8-bit identity code without any dedicated pins. It reuses three signals that already cross the connector. The host holds the card reset asserted, uses the write strobe as a shift clock, and uses the two card-enable lines to pick between loading the code and reading it. The code comes back one bit at a time on the slot-0 card-detect line. When the card reset is released, that line carries the real card-present level again.

A host first applies one strobe pulse with enable A high and enable B low. This loads the code, and bit 0 is visible at once. The host then switches to enable A low and enable B high. It samples the detect line and then pulses the strobe, once for each bit, least significant bit first. The default code is 8'hC2, which marks a dual-slot card. The strobe is asynchronous to the local clock. It passes through a two-flop synchronizer, and its rising edge is detected before it is used.

The controller has three states. In `ST_EMPTY` nothing has been loaded since local reset. In `ST_HOLD` the register holds code bits that have not yet been shifted out. In `ST_DRAINED` all 8 bits have been shifted out and only zeros remain. Transitions: a load pulse takes any state to `ST_HOLD`. A read pulse in `ST_HOLD` stays in `ST_HOLD` until the eighth shift, which moves to `ST_DRAINED`. A read pulse in `ST_EMPTY` or `ST_DRAINED` keeps the state.

Top module: `board_id_shifter`

## Requirements
- R1: A strobe pulse with `cen_a`=1 and `cen_b`=0 while `card_reset`=1 loads the identity code (default 8'hC2) into the register.
- R2: Right after a load, with `card_reset`=1, `detect_n` shows code bit 0 before any read pulse.
- R3: With `cen_a`=0 and `cen_b`=1, each strobe pulse moves the output to the next code bit, least significant bit first. For 8'hC2 the host sees 0,1,0,0,0,0,1,1.
- R4: After 8 read pulses the output is 0 and stays 0 for further read pulses.
- R5: A new load pulse restores the full code, whatever the number of bits already read.
- R6: With `card_reset`=0, `detect_n` equals `present_n`.
- R7: Strobe pulses while `card_reset`=0 leave the register unchanged.
- R8: Strobe pulses with both enables low or both enables high leave the register unchanged.
- R9: Only a completed low-then-high strobe pulse counts. A falling edge alone does not move the output; the following rise does.
- R10: After local reset (`rst_n` low) the register is empty. With `card_reset`=1 the output reads 0, and read pulses before any load keep it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Local asynchronous reset, active low |
| card_reset | input | 1 | Card reset from host, 1 = held in reset (identity mode) |
| strobe_n | input | 1 | Write strobe used as shift clock, idles high |
| cen_a | input | 1 | Card enable A (1 with `cen_b`=0 selects load) |
| cen_b | input | 1 | Card enable B (1 with `cen_a`=0 selects read) |
| present_n | input | 1 | Real card-present level, active low |
| detect_n | output | 1 | Slot-0 card-detect: serial code bit in identity mode, else `present_n` |

## Verification
The bench loads the code and reads every depth from zero to ten pulses. This separates the shift order, the point where the code runs out and the zero fill after it, and reloads from each depth to show that a load restores the code. At every depth it also applies pulses in both idle enable patterns, with card reset released, and with only a falling strobe edge. Any change of the visible bit in those cases marks a register update that should not have happened. Separate patterns drive `present_n` both ways with card reset released, and read pulses straight after local reset to show that the register starts empty.

// File: rtl/board_id_pkg.sv
package board_id_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_HOLD    = 2'd1,
        ST_DRAINED = 2'd2
    } id_state_t;

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_LOAD = 2'd1,
        MD_READ = 2'd2
    } id_mode_t;

    function automatic id_mode_t decode_mode(input logic en_a, input logic en_b);
        if (en_a && !en_b)
            return MD_LOAD;
        else if (!en_a && en_b)
            return MD_READ;
        else
            return MD_IDLE;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic rise
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pipe <= '1;
        else
            pipe <= {pipe[STAGES-1:0], strobe_n};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];

    // R9: one completed pulse yields a single-cycle step
    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/id_shift_fsm.sv
module id_shift_fsm
    import board_id_pkg::*;
#(
    parameter int              WIDTH   = 8,
    parameter logic [WIDTH-1:0] ID_CODE = 8'hC2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic card_reset,
    input  logic en_a,
    input  logic en_b,
    output logic serial_bit
);
    localparam int CW = $clog2(WIDTH + 1);

    id_state_t        state, state_n;
    logic [WIDTH-1:0] sreg, sreg_n;
    logic [CW-1:0]    cnt, cnt_n;
    id_mode_t         mode;
    logic             act;

    assign mode = decode_mode(en_a, en_b);
    assign act  = step && card_reset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_EMPTY;
        else
            state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else begin
            sreg <= sreg_n;
            cnt  <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        sreg_n  = sreg;
        cnt_n   = cnt;
        if (act && mode == MD_LOAD) begin
            state_n = ST_HOLD;
            sreg_n  = ID_CODE;
            cnt_n   = '0;
        end else if (act && mode == MD_READ) begin
            unique case (state)
                ST_EMPTY: begin
                    state_n = ST_EMPTY;
                end
                ST_HOLD: begin
                    sreg_n = sreg >> 1;
                    cnt_n  = cnt + 1'b1;
                    if (cnt == CW'(WIDTH - 1))
                        state_n = ST_DRAINED;
                end
                ST_DRAINED: begin
                    sreg_n = '0;
                end
                default: state_n = ST_EMPTY;
            endcase
        end
    end

    assign serial_bit = sreg[0];

    a_r1_load_code: assert property (@(posedge clk) disable iff (!rst_n)
        (step && card_reset && en_a && !en_b) |=> (sreg == ID_CODE));

    a_r3_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
        (step && card_reset && !en_a && en_b && state == ST_HOLD)
            |=> (sreg == ($past(sreg) >> 1)));

    a_r4_drained_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAINED) |-> (sreg == '0));

    a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !card_reset |=> $stable(sreg));

    a_r8_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a == en_b) |=> $stable(sreg));

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(WIDTH));

endmodule

// File: rtl/board_id_shifter.sv
module board_id_shifter #(
    parameter int               WIDTH       = 8,
    parameter logic [WIDTH-1:0] ID_CODE     = 8'hC2,
    parameter int               SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_reset,
    input  logic strobe_n,
    input  logic cen_a,
    input  logic cen_b,
    input  logic present_n,
    output logic detect_n
);
    logic step;
    logic serial_bit;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .rise     (step)
    );

    id_shift_fsm #(.WIDTH(WIDTH), .ID_CODE(ID_CODE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .card_reset (card_reset),
        .en_a       (cen_a),
        .en_b       (cen_b),
        .serial_bit (serial_bit)
    );

    assign detect_n = card_reset ? serial_bit : present_n;

    // R6: outside identity mode the detect line is the card-present level
    a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_reset && !$past(card_reset)) |-> (detect_n == present_n));

endmodule

// File: tb/board_id_shifter_bench.sv
module board_id_shifter_bench;
    localparam logic [7:0] CODE = 8'hC2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_reset = 1'b0;
    logic strobe_n = 1'b1;
    logic cen_a = 1'b0;
    logic cen_b = 1'b0;
    logic present_n = 1'b1;
    logic detect_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    board_id_shifter u_board_id_shifter (
        .clk(clk), .rst_n(rst_n), .card_reset(card_reset), .strobe_n(strobe_n),
        .cen_a(cen_a), .cen_b(cen_b), .present_n(present_n), .detect_n(detect_n)
    );

    function automatic logic exp_bit(input int n);
        return (n < 8) ? CODE[n] : 1'b0;
    endfunction

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic exp);
        checks++;
        if (detect_n !== exp) begin
            fails++;
            $display("FAIL %s: detect_n=%b expected %b", tag, detect_n, exp);
        end
    endtask

    task automatic set_mode(input logic a, input logic b);
        cen_a = a; cen_b = b;
        wait_cyc(2);
    endtask

    task automatic pulse();
        strobe_n = 1'b0;
        wait_cyc(4);
        strobe_n = 1'b1;
        wait_cyc(6);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);

        // R10: empty after reset, reads before load give zero
        card_reset = 1'b1;
        wait_cyc(1);
        chk("R10 empty", 1'b0);
        set_mode(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            pulse();
            chk("R10 read before load", 1'b0);
        end

        // R6: passthrough when card reset released
        card_reset = 1'b0;
        for (int i = 0; i < 4; i++) begin
            present_n = i[0];
            wait_cyc(1);
            chk("R6 passthrough", i[0]);
        end
        present_n = 1'b1;

        for (int k = 0; k <= 10; k++) begin
            card_reset = 1'b1;
            set_mode(1'b1, 1'b0);
            pulse();
            chk((k == 0) ? "R1 R2 load bit0" : "R5 reload bit0", exp_bit(0));
            set_mode(1'b0, 1'b1);
            for (int n = 0; n < k; n++) begin
                pulse();
                chk((n + 1 < 8) ? "R3 shift order" : "R4 zero fill", exp_bit(n + 1));
            end
            // R8: idle enable patterns
            set_mode(1'b0, 1'b0);
            pulse();
            chk("R8 both low ignored", exp_bit(k));
            set_mode(1'b1, 1'b1);
            pulse();
            chk("R8 both high ignored", exp_bit(k));
            // R7: pulse while card reset released
            set_mode(1'b0, 1'b1);
            card_reset = 1'b0;
            wait_cyc(1);
            pulse();
            card_reset = 1'b1;
            wait_cyc(1);
            chk("R7 gated by card reset", exp_bit(k));
            // R9: falling edge alone does nothing, rise advances
            strobe_n = 1'b0;
            wait_cyc(8);
            chk("R9 fall only", exp_bit(k));
            strobe_n = 1'b1;
            wait_cyc(6);
            chk("R9 rise advances", exp_bit(k + 1));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule